// File: doc/BRIEF.md
# Instrument-Bus DMA Byte Mover

This block sits between a host DMA channel and a byte-wide instrument-bus handshake engine. The host moves data through a request/acknowledge pair and read/write strobes. A transfer is either one 16-bit word or one byte. The data passes through two byte-wide FIFOs, called lane A and lane B, and leaves them in strict byte order. On the bus side the block either offers bytes to a talker handshake (`tx_valid`/`tx_done`) or takes bytes from a listener handshake (`rx_valid`/`rx_ready`).

A wide transfer counter is loaded before the transfer starts. It counts down once for every byte whose bus handshake completes. When it reaches zero, a terminal flag stops the bus side and stops DMA requests in talk direction. Two options act on the last byte:
- In talk direction, END can be marked on the last byte.
- In listen direction, a ready holdoff can stop any further byte from being accepted.

A completion status bit rises only when the last byte's bus handshake has finished. It stays set until it is explicitly cleared; reading it does not clear it. While the bus attention line is asserted, the byte being offered is held back and kept. It is not lost.

Top module: `gpib_dma_xfer`

## Requirements
- R1: With `host_wide`=1, a DACK-qualified write puts `host_wdata[15:8]` into lane A and `host_wdata[7:0]` into lane B. In talk direction (`dir_talk`=1), bytes leave on `tx_data` as lane A then lane B for each word, in the order the words were written.
- R2: With `host_wide`=0, each DACK-qualified access uses only `host_wdata[7:0]` or `host_rdata[7:0]`. It goes to the lane that is next in order, and the lanes alternate starting from lane A, so byte order is kept in both directions. A wide listen-direction read returns the lane A byte on `host_rdata[15:8]` and the lane B byte on `host_rdata[7:0]`.
- R3: `cnt_load` loads `cnt_value`. The counter then decrements once for each completed bus byte. After the byte that brings it to zero, `tx_valid` stays low in talk direction.
- R4: `tx_end` is high with a presented byte only when `auto_end_en`=1 and that byte is the last one to be counted.
- R5: In listen direction with `holdoff_en`=1, `rx_ready` goes low once the terminal byte has been accepted, and no further byte is taken. With `holdoff_en`=0, `rx_ready` stays high.
- R6: `irq_done` is low while the last byte is still being offered. It rises in the cycle after that byte's handshake completes.
- R7: In talk direction, `drq` is high while enabled, while neither lane is full and while the terminal flag is clear. It drops when a lane fills or the count is reached. In listen direction, `drq` is high only while the next byte in order is available.
- R8: While `atn` is high, no byte is presented or counted. The pending byte is presented unchanged once `atn` falls.
- R9: `irq_done` and `stat_end` (END received in listen direction) stay set until `stat_clr` is pulsed; reading data does not clear them.
- R10: After reset both FIFOs are empty, and `drq`, `tx_valid`, `irq_done` and `stat_end` are low.
- R11: A strobe with `dack_n`=1 has no effect on the FIFOs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_en | input | 1 | Enable transfer |
| dir_talk | input | 1 | 1 = host to bus, 0 = bus to host |
| auto_end_en | input | 1 | Mark END on the last byte |
| holdoff_en | input | 1 | Hold off ready after the last byte |
| cnt_load | input | 1 | Load transfer count |
| cnt_value | input | 32 | Transfer count |
| stat_clr | input | 1 | Clear status bits |
| drq | output | 1 | DMA request |
| dack_n | input | 1 | DMA acknowledge, active low |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wide | input | 1 | 1 = 16-bit access |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| atn | input | 1 | Bus attention |
| tx_valid | output | 1 | Byte offered to talker handshake |
| tx_data | output | 8 | Offered byte |
| tx_end | output | 1 | END with offered byte |
| tx_done | input | 1 | Handshake of offered byte complete |
| rx_valid | input | 1 | Listener byte available |
| rx_data | input | 8 | Listener byte |
| rx_end | input | 1 | END received with byte |
| rx_ready | output | 1 | Block accepts listener byte |
| irq_done | output | 1 | Transfer complete status |
| stat_end | output | 1 | END received status |

## Verification
Suppose a lane selector is wrong. Then bytes on `tx_data` or `host_rdata` come out swapped or repeated at the first word boundary, within two bytes of the fault. A counter that is off by one shows as `tx_end` or `irq_done` appearing one byte early or late. It also shows as `rx_ready` dropping at the wrong byte. A FIFO occupancy error shows as `drq` staying high past the sixteenth word, or dropping too early. A lost ATN byte shows as a skipped value on `tx_data` right after `atn` falls.

// File: rtl/gdx_pkg.sv
// Shared lane indices for the DMA byte mover.
package gdx_pkg;
    localparam int LANE_A = 0;  // upper byte lane, first in byte order
    localparam int LANE_B = 1;  // lower byte lane, second in byte order
    localparam int NLANE  = 2;
endpackage

// File: rtl/gdx_fifo.sv
// Show-ahead synchronous FIFO for one byte lane.
// Assumes the caller never pushes when full or pops when empty.
module gdx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          full,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
        end
    end

    assign rdata = mem[rp];
    assign full  = (cnt == (AW+1)'(DEPTH));
    assign empty = (cnt == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R1
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R2
endmodule

// File: rtl/gdx_bytecnt.sv
// Transfer byte counter: load, decrement per completed bus byte, terminal flag.
// Saturates at zero; the terminal flag is set by the decrement that reaches zero.
module gdx_bytecnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] value,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             last,
    output logic             tc
);
    assign last = (cnt == CNT_W'(1));

    // Count register and terminal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            tc  <= 1'b0;
        end else if (load) begin
            cnt <= value;
            tc  <= 1'b0;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (last) tc <= 1'b1;
        end
    end

    AST_TC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) tc |-> (cnt == '0)); // R3
endmodule

// File: rtl/gpib_dma_xfer.sv
// DMA byte mover between a host DMA channel and a byte-wide bus handshake.
// Two lane FIFOs keep byte order A,B,A,B. The counter ends the transfer.
// Assumes the host issues wide accesses only at lane A alignment.
module gpib_dma_xfer #(
    parameter int BYTE_W     = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xfer_en,
    input  logic                dir_talk,
    input  logic                auto_end_en,
    input  logic                holdoff_en,
    input  logic                cnt_load,
    input  logic [CNT_W-1:0]    cnt_value,
    input  logic                stat_clr,
    output logic                drq,
    input  logic                dack_n,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic                host_wide,
    input  logic [2*BYTE_W-1:0] host_wdata,
    output logic [2*BYTE_W-1:0] host_rdata,
    input  logic                atn,
    output logic                tx_valid,
    output logic [BYTE_W-1:0]   tx_data,
    output logic                tx_end,
    input  logic                tx_done,
    input  logic                rx_valid,
    input  logic [BYTE_W-1:0]   rx_data,
    input  logic                rx_end,
    output logic                rx_ready,
    output logic                irq_done,
    output logic                stat_end
);
    import gdx_pkg::*;

    logic [NLANE-1:0] push, pop, full, empty;
    logic [BYTE_W-1:0] wdat [NLANE];
    logic [BYTE_W-1:0] head [NLANE];
    logic hsel, bsel;
    logic [CNT_W-1:0] cnt_q;
    logic last, tc;
    logic acc_wr, acc_rd, wide_room, wide_avail, tx_take, rx_take, byte_done;
    logic done_q, end_q;

    // Qualified host accesses and lane availability.
    assign acc_wr     = host_wr & ~dack_n & xfer_en &  dir_talk;
    assign acc_rd     = host_rd & ~dack_n & xfer_en & ~dir_talk;
    assign wide_room  = ~full[LANE_A] & ~full[LANE_B];
    assign wide_avail = ~empty[LANE_A] & ~empty[LANE_B];

    // Bus side handshakes.
    assign tx_valid  = xfer_en & dir_talk & ~tc & ~empty[bsel] & ~atn;
    assign tx_data   = head[bsel];
    assign tx_end    = auto_end_en & last;
    assign tx_take   = tx_valid & tx_done;
    assign rx_ready  = xfer_en & ~dir_talk & ~full[bsel] & ~(holdoff_en & tc);
    assign rx_take   = rx_valid & rx_ready;
    assign byte_done = tx_take | rx_take;

    genvar l;
    generate
        for (l = 0; l < NLANE; l++) begin : g_lane
            // Lane write data: upper host byte to lane A on wide writes.
            always_comb begin
                if (!dir_talk)                     wdat[l] = rx_data;
                else if (host_wide && l == LANE_A) wdat[l] = host_wdata[2*BYTE_W-1:BYTE_W];
                else                               wdat[l] = host_wdata[BYTE_W-1:0];
            end
            // Lane push and pop decisions.
            always_comb begin
                if (dir_talk) begin
                    push[l] = acc_wr & (host_wide ? wide_room : (hsel == l[0] && !full[l]));
                    pop[l]  = tx_take & (bsel == l[0]);
                end else begin
                    push[l] = rx_take & (bsel == l[0]);
                    pop[l]  = acc_rd & (host_wide ? wide_avail : (hsel == l[0] && !empty[l]));
                end
            end
            gdx_fifo #(.DW(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
                .clk(clk), .rst_n(rst_n), .push(push[l]), .pop(pop[l]),
                .wdata(wdat[l]), .rdata(head[l]), .full(full[l]), .empty(empty[l])
            );
        end
    endgenerate

    gdx_bytecnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .value(cnt_value),
        .dec(byte_done), .cnt(cnt_q), .last(last), .tc(tc)
    );

    // Lane selectors: host side advances on narrow accesses, bus side per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsel <= 1'b0;
            bsel <= 1'b0;
        end else begin
            if (!host_wide && (push[hsel] && dir_talk || pop[hsel] && !dir_talk))
                hsel <= ~hsel;
            if (byte_done) bsel <= ~bsel;
        end
    end

    // Host read data and request pacing.
    assign host_rdata = host_wide ? {head[LANE_A], head[LANE_B]}
                                  : {{BYTE_W{1'b0}}, head[hsel]};
    assign drq = dir_talk ? (xfer_en & ~tc & wide_room)
                          : (xfer_en & ~empty[hsel]);

    // Static status bits, cleared only by an explicit write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            end_q  <= 1'b0;
        end else if (stat_clr) begin
            done_q <= 1'b0;
            end_q  <= 1'b0;
        end else begin
            if (byte_done && last) done_q <= 1'b1;
            if (rx_take && rx_end) end_q  <= 1'b1;
        end
    end
    assign irq_done = done_q;
    assign stat_end = end_q;

    AST_END_ONLY_LAST: assert property (@(posedge clk) disable iff (!rst_n) (tx_valid && tx_end) |-> (cnt_q == CNT_W'(1))); // R4
    AST_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n) (!dir_talk && holdoff_en && tc) |-> !rx_ready); // R5
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (irq_done && !stat_clr) |=> irq_done); // R9
    AST_ATN_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (atn && dir_talk && !cnt_load) |=> $stable(cnt_q)); // R8
    AST_DRQ_STOP: assert property (@(posedge clk) disable iff (!rst_n) (dir_talk && tc) |-> !drq); // R7
endmodule

// File: tb/tb_gpib_dma_xfer.sv
module tb_gpib_dma_xfer;
    logic clk = 0, rst_n = 0;
    logic xfer_en = 0, dir_talk = 0, auto_end_en = 0, holdoff_en = 0, cnt_load = 0, stat_clr = 0;
    logic [31:0] cnt_value = 0;
    logic drq, dack_n = 1, host_wr = 0, host_rd = 0, host_wide = 0;
    logic [15:0] host_wdata = 0, host_rdata;
    logic atn = 0, tx_valid, tx_end, tx_done = 0;
    logic [7:0] tx_data, rx_data = 0;
    logic rx_valid = 0, rx_end = 0, rx_ready, irq_done, stat_end;
    int nchk = 0, nfail = 0;
    bit finished = 0;

    localparam logic [15:0] WORDS [4] = '{16'hA1B2, 16'hC3D4, 16'h0FF0, 16'h5A96};

    always #4 clk = ~clk;

    gpib_dma_xfer dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic do_reset();
        rst_n = 0; xfer_en = 0; atn = 0; tx_done = 0; rx_valid = 0; rx_end = 0;
        host_wr = 0; host_rd = 0; dack_n = 1; auto_end_en = 0; holdoff_en = 0;
        repeat (2) tick();
        rst_n = 1; tick();
    endtask

    task automatic start(input logic talk, input logic [31:0] n);
        dir_talk = talk; cnt_value = n; cnt_load = 1; tick();
        cnt_load = 0; xfer_en = 1; #1;
    endtask

    task automatic hwrite(input logic wide, input logic [15:0] d);
        host_wide = wide; host_wdata = d; host_wr = 1; dack_n = 0; tick();
        host_wr = 0; dack_n = 1; #1;
    endtask

    task automatic lpush(input logic [7:0] d, input logic e);
        rx_data = d; rx_end = e; rx_valid = 1; tick();
        rx_valid = 0; rx_end = 0; #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10: reset state
        chk("R10 drq", drq, 0); chk("R10 tx_valid", tx_valid, 0);
        chk("R10 irq", irq_done, 0); chk("R10 stat_end", stat_end, 0);

        // Table-driven talk transfer, wide writes, END on last byte.
        auto_end_en = 1;
        start(1, 8);
        chk("R7 drq talk idle", drq, 1);
        // R11: strobe without DACK ignored
        host_wide = 1; host_wdata = 16'hDEAD; host_wr = 1; dack_n = 1; tick(); host_wr = 0; #1;
        chk("R11 no byte", tx_valid, 0);
        foreach (WORDS[i]) hwrite(1, WORDS[i]);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] exp;
            exp = (i % 2 == 0) ? WORDS[i/2][15:8] : WORDS[i/2][7:0];
            if (i == 3) begin
                atn = 1; tx_done = 1; #1;
                chk("R8 atn blocks", tx_valid, 0);
                tick(); atn = 0; tx_done = 0; #1;
                chk("R8 byte kept", tx_data, exp);
            end
            chk("R1 valid", tx_valid, 1);
            chk("R1 order", tx_data, exp);
            chk("R4 end", tx_end, (i == 7));
            if (i == 7) chk("R6 irq before handshake", irq_done, 0);
            tx_done = 1; tick(); tx_done = 0; #1;
        end
        chk("R6 irq after last", irq_done, 1);
        chk("R3 bus stops", tx_valid, 0);
        chk("R7 drq at tc", drq, 0);
        repeat (3) tick();
        chk("R9 status static", irq_done, 1);
        stat_clr = 1; tick(); stat_clr = 0; #1;
        chk("R9 cleared", irq_done, 0);

        // Narrow talk writes, no END option.
        do_reset();
        start(1, 2);
        hwrite(0, 16'h00AB); hwrite(0, 16'h00CD);
        chk("R2 narrow first", tx_data, 8'hAB);
        chk("R4 no end when off", tx_end, 0);
        tx_done = 1; tick(); tx_done = 0; #1;
        chk("R2 narrow second", tx_data, 8'hCD);

        // FIFO full pacing.
        do_reset();
        atn = 1;
        start(1, 100);
        for (int i = 0; i < 15; i++) hwrite(1, 16'(i));
        chk("R7 drq room", drq, 1);
        hwrite(1, 16'hFFFF);
        chk("R7 drq full", drq, 0);

        // Listen with holdoff.
        do_reset();
        holdoff_en = 1;
        start(0, 3);
        chk("R7 drq empty listen", drq, 0);
        chk("R5 ready", rx_ready, 1);
        lpush(8'h11, 0); lpush(8'h22, 1); lpush(8'h33, 0);
        chk("R5 holdoff", rx_ready, 0);
        chk("R6 irq listen", irq_done, 1);
        chk("R9 end seen", stat_end, 1);
        rx_data = 8'h44; rx_valid = 1; tick(); tick(); rx_valid = 0; #1;
        for (int i = 0; i < 3; i++) begin
            chk("R7 drq data", drq, 1);
            host_wide = 0; host_rd = 1; dack_n = 0; #1;
            chk("R2 listen order", host_rdata[7:0], 8'h11 * (i + 1));
            tick(); host_rd = 0; dack_n = 1; #1;
        end
        chk("R5 extra byte refused", drq, 0);
        chk("R9 end static", stat_end, 1);

        // Listen without holdoff, then wide read lanes.
        do_reset();
        start(0, 2);
        lpush(8'h5A, 0); lpush(8'hA5, 0);
        chk("R5 no holdoff", rx_ready, 1);
        host_wide = 1; host_rd = 1; dack_n = 0; #1;
        chk("R2 wide read", host_rdata, 16'h5AA5);
        tick(); host_rd = 0; dack_n = 1; #1;
        chk("R7 drq drained", drq, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule